// File: doc/BRIEF.md
# Fixed-Latency Transposed FIR Filter

This block is a fully parallel FIR filter in transposed form whose coefficients are fixed when the design is elaborated. It takes one signed fixed-point sample per clock, qualified by a valid strobe. It returns one filtered sample per accepted input, qualified by its own valid strobe. The delay from input to output is a constant number of cycles and does not depend on how many taps exist or what values they hold.

Area is reduced at elaboration time. Every distinct nonzero coefficient magnitude gets exactly one multiplier. Each tap picks up the product that belongs to its magnitude and either adds or subtracts it in the transposed adder chain, depending on the sign of its coefficient. A tap whose coefficient is zero has no multiplier and no adder.

The full-precision sum is scaled down by a fixed number of fraction bits. A rounding rule chosen by parameter is applied during that step. The result is then narrowed to the output width, either with clamping or by plain wrap-around.

Top module: `fir_xposed_fixlat`

## Requirements
- R1: An input accepted with in_valid high at a rising edge appears with out_valid high after exactly six rising edges, counting the edge that accepted it. The tap values do not change this delay.
- R2: Inputs may be valid on every cycle, and each one produces exactly one output in order.
- R3: The output before scaling equals the sum over taps k of c_k * x[n-k]. Tap k is bits [k*COEF_W +: COEF_W] of COEFS, taken as signed. x[n-k] is the k-th most recent accepted sample, and samples from before the last reset count as zero.
- R4: Taps with equal coefficient magnitude share one product. A negative tap subtracts that shared product, so the impulse response reproduces every tap with its correct sign.
- R5: A zero tap contributes nothing to the output.
- R6: A cycle with in_valid low does not shift the delay chain and produces no output. While out_valid is low, out_data keeps its last value.
- R7: The sum is shifted right by SHIFT bits using the rounding rule given by RND. The encodings are: 0 = floor; 1 = ceiling; 2 = nearest with ties toward +inf; 3 = toward zero; 4 = nearest with ties to even.
- R8: With SAT_EN=1, a scaled result outside the signed OUT_W range is clamped to the nearest limit. With SAT_EN=0, only the low OUT_W bits are kept. The scaled width must exceed OUT_W.
- R9: A synchronous active-high rst clears out_valid, out_data and the whole delay history, whatever the value of in_valid during reset.
- R10: out_valid stays low during the first six edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies in_data |
| in_data | input | DATA_W | Signed input sample |
| out_valid | output | 1 | Qualifies out_data |
| out_data | output | OUT_W | Signed, rounded and cast output sample |

## Verification
The bound checker checks the timing side on every cycle. It confirms that out_valid is in_valid delayed by exactly six edges, that the output is quiet right after reset, that it starts from cleared values, and that out_data holds whenever no output is produced. The numerical content can only be shown by the bench scenarios. These are sign handling on shared products, silent zero taps, the five rounding rules, and clamping versus wrap. The bench runs six instances with different rounding and saturation settings on the same stimulus and compares each against arithmetic computed in the bench. The stimulus includes a full sweep of all input codes, inputs with gaps, and patterns built to push the sum past the output range.

// File: rtl/fir_xf_pkg.sv
package fir_xf_pkg;

  typedef enum logic [2:0] {
    RND_FLOOR   = 3'd0,
    RND_CEIL    = 3'd1,
    RND_NEAREST = 3'd2,
    RND_ZERO    = 3'd3,
    RND_CONV    = 3'd4
  } rnd_mode_e;

  // Coefficient vectors are zero-extended to this width for elaboration helpers.
  localparam int CV_BITS = 1024;

  // Signed value of tap k in a packed vector of w-bit coefficients.
  function automatic int coef_at(logic [CV_BITS-1:0] cv, int w, int k);
    logic [CV_BITS-1:0] sh;
    int r;
    sh = cv >> (k * w);
    r = int'(sh[31:0] & ((32'd1 << w) - 32'd1));
    if (r >= (1 << (w - 1))) r = r - (1 << w);
    return r;
  endfunction

  function automatic int abs_i(int v);
    return (v < 0) ? -v : v;
  endfunction

  // Lowest-index tap that has the same magnitude as tap k.
  function automatic int owner_of(logic [CV_BITS-1:0] cv, int w, int k);
    int o;
    o = k;
    for (int j = k; j >= 0; j--) begin
      if (abs_i(coef_at(cv, w, j)) == abs_i(coef_at(cv, w, k))) o = j;
    end
    return o;
  endfunction

endpackage

// File: rtl/fir_xf_mult_bank.sv
// Input register plus one registered multiplier per distinct nonzero magnitude.
module fir_xf_mult_bank
  import fir_xf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int NTAPS  = 6,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
  parameter int PW     = DATA_W + COEF_W + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     prod_valid,
  output logic signed [PW-1:0]     prod [NTAPS]
);

  localparam logic [CV_BITS-1:0] CV = CV_BITS'(COEFS);

  logic                     x_v;
  logic signed [DATA_W-1:0] x_q;
  logic signed [PW-1:0]     x_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      x_v        <= 1'b0;
      x_q        <= '0;
      prod_valid <= 1'b0;
    end else begin
      x_v        <= in_valid;
      prod_valid <= x_v;
      if (in_valid) x_q <= in_data;
    end
  end

  assign x_ext = {{(PW-DATA_W){x_q[DATA_W-1]}}, x_q};

  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    localparam int C   = coef_at(CV, COEF_W, k);
    localparam int OWN = owner_of(CV, COEF_W, k);
    if (OWN == k && C != 0) begin : g_mul
      localparam logic signed [PW-1:0] MAG = PW'(abs_i(C));
      logic signed [PW-1:0] p_r;
      always_ff @(posedge clk) begin
        if (rst)      p_r <= '0;
        else if (x_v) p_r <= x_ext * MAG;
      end
      assign prod[k] = p_r;
    end else begin : g_nomul
      assign prod[k] = '0;
    end
  end

endmodule

// File: rtl/fir_xf_chain.sv
// Transposed adder chain; each tap adds or subtracts its magnitude owner's product.
module fir_xf_chain
  import fir_xf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int NTAPS  = 6,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = '0,
  parameter int PW     = DATA_W + COEF_W + 1,
  parameter int ACC_W  = DATA_W + COEF_W + $clog2(NTAPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    prod_valid,
  input  logic signed [PW-1:0]    prod [NTAPS],
  output logic                    sum_valid,
  output logic signed [ACC_W-1:0] sum_q
);

  localparam logic [CV_BITS-1:0] CV = CV_BITS'(COEFS);

  logic signed [ACC_W-1:0] inc [NTAPS];
  logic signed [ACC_W-1:0] upd [NTAPS];
  logic signed [ACC_W-1:0] z   [NTAPS-1];

  for (genvar k = 0; k < NTAPS; k++) begin : g_stage
    localparam int C   = coef_at(CV, COEF_W, k);
    localparam int OWN = owner_of(CV, COEF_W, k);

    if (k == NTAPS - 1) begin : g_end
      assign inc[k] = '0;
    end else begin : g_mid
      assign inc[k] = z[k];
      always_ff @(posedge clk) begin
        if (rst)             z[k] <= '0;
        else if (prod_valid) z[k] <= upd[k+1];
      end
    end

    if (C == 0) begin : g_skip
      assign upd[k] = inc[k];
    end else begin : g_add
      logic signed [ACC_W-1:0] ext;
      assign ext = {{(ACC_W-PW){prod[OWN][PW-1]}}, prod[OWN]};
      if (C > 0) begin : g_pos
        assign upd[k] = inc[k] + ext;
      end else begin : g_neg
        assign upd[k] = inc[k] - ext;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_valid <= 1'b0;
      sum_q     <= '0;
    end else begin
      sum_valid <= prod_valid;
      if (prod_valid) sum_q <= upd[0];
    end
  end

endmodule

// File: rtl/fir_xf_cast.sv
// Rounding, narrowing with optional clamp, and padding stages to the fixed latency.
module fir_xf_cast
  import fir_xf_pkg::*;
#(
  parameter int        ACC_W  = 20,
  parameter int        SHIFT  = 2,
  parameter int        OUT_W  = 10,
  parameter rnd_mode_e RND    = RND_FLOOR,
  parameter bit        SAT_EN = 1'b1,
  parameter int        PAD    = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sum_valid,
  input  logic signed [ACC_W-1:0] sum_q,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int QW = ACC_W - SHIFT + 1;
  localparam logic [SHIFT-1:0] HALF = SHIFT'(1) << (SHIFT - 1);
  localparam logic signed [QW-1:0] HI = QW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [QW-1:0] LO = -HI - QW'(1);

  logic signed [ACC_W-SHIFT-1:0] flo;
  logic [SHIFT-1:0]              rem;
  logic                          bump;
  logic signed [QW-1:0]          q_r;
  logic                          q_v;
  logic signed [OUT_W-1:0]       narrow;
  logic                          pv [PAD+1];
  logic signed [OUT_W-1:0]       pd [PAD+1];

  assign flo = sum_q[ACC_W-1:SHIFT];
  assign rem = sum_q[SHIFT-1:0];

  always_comb begin
    unique case (RND)
      RND_CEIL:    bump = (rem != '0);
      RND_NEAREST: bump = (rem >= HALF);
      RND_ZERO:    bump = sum_q[ACC_W-1] && (rem != '0);
      RND_CONV:    bump = (rem > HALF) || ((rem == HALF) && flo[0]);
      default:     bump = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_v <= 1'b0;
      q_r <= '0;
    end else begin
      q_v <= sum_valid;
      if (sum_valid) q_r <= $signed({flo[ACC_W-SHIFT-1], flo}) + $signed({{(QW-1){1'b0}}, bump});
    end
  end

  if (SAT_EN) begin : g_clamp
    assign narrow = (q_r > HI) ? HI[OUT_W-1:0] :
                    (q_r < LO) ? LO[OUT_W-1:0] : q_r[OUT_W-1:0];
  end else begin : g_wrap
    assign narrow = q_r[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= PAD; i++) begin
        pv[i] <= 1'b0;
        pd[i] <= '0;
      end
    end else begin
      pv[0] <= q_v;
      if (q_v) pd[0] <= narrow;
      for (int i = 1; i <= PAD; i++) begin
        pv[i] <= pv[i-1];
        if (pv[i-1]) pd[i] <= pd[i-1];
      end
    end
  end

  assign out_valid = pv[PAD];
  assign out_data  = pd[PAD];

endmodule

// File: rtl/fir_xposed_fixlat.sv
module fir_xposed_fixlat
  import fir_xf_pkg::*;
#(
  parameter int        DATA_W = 8,
  parameter int        COEF_W = 8,
  parameter int        NTAPS  = 6,
  parameter logic [NTAPS*COEF_W-1:0] COEFS = 48'h03_FD_05_00_FB_03,
  parameter int        SHIFT  = 2,
  parameter int        OUT_W  = 10,
  parameter rnd_mode_e RND    = RND_FLOOR,
  parameter bit        SAT_EN = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_data,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_data
);

  localparam int LATENCY = 6;
  localparam int FIXED   = 5;   // input, product, chain, round, narrow
  localparam int PAD     = LATENCY - FIXED;
  localparam int PW      = DATA_W + COEF_W + 1;
  localparam int ACC_W   = DATA_W + COEF_W + $clog2(NTAPS) + 1;

  logic                    prod_valid;
  logic signed [PW-1:0]    prod [NTAPS];
  logic                    sum_valid;
  logic signed [ACC_W-1:0] sum_q;

  fir_xf_mult_bank #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .COEFS(COEFS), .PW(PW)
  ) u_mult (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .prod_valid(prod_valid), .prod(prod)
  );

  fir_xf_chain #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .NTAPS(NTAPS), .COEFS(COEFS),
    .PW(PW), .ACC_W(ACC_W)
  ) u_chain (
    .clk(clk), .rst(rst), .prod_valid(prod_valid), .prod(prod),
    .sum_valid(sum_valid), .sum_q(sum_q)
  );

  fir_xf_cast #(
    .ACC_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W), .RND(RND),
    .SAT_EN(SAT_EN), .PAD(PAD)
  ) u_cast (
    .clk(clk), .rst(rst), .sum_valid(sum_valid), .sum_q(sum_q),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/fir_xposed_fixlat_chk.sv
module fir_xposed_fixlat_chk #(
  parameter int OUT_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);

  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst < 3'd7) since_rst <= since_rst + 3'd1;
  end

  // R1: output strobe is the input strobe six edges later
  a_r1_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd6) |-> (out_valid == $past(in_valid, 6)));

  // R10: no output before the pipeline can hold an accepted sample
  a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
    (since_rst < 3'd6) |-> !out_valid);

  // R6: output data only moves together with a valid output
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (out_valid || $stable(out_data)));

  // R9: reset leaves cleared outputs
  a_r9_cleared: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd0) |-> (!out_valid && out_data == '0));

endmodule

bind fir_xposed_fixlat fir_xposed_fixlat_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/fir_xposed_fixlat_bench.sv
module fir_xposed_fixlat_bench;
  import fir_xf_pkg::*;

  localparam int NCFG = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [7:0] in_data = '0;
  logic vo [NCFG];
  logic signed [9:0] yo [NCFG];

  always #4 clk = ~clk;

  // configs 0..4: rounding rule g with clamping; config 5: floor with wrap
  for (genvar g = 0; g < NCFG; g++) begin : g_cfg
    localparam rnd_mode_e MODE = rnd_mode_e'((g < 5) ? g : 0);
    localparam bit SAT = (g < 5);
    fir_xposed_fixlat #(
      .DATA_W(8), .COEF_W(8), .NTAPS(6), .COEFS(48'h03_FD_05_00_FB_03),
      .SHIFT(2), .OUT_W(10), .RND(MODE), .SAT_EN(SAT)
    ) u_fir_xposed_fixlat (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
      .out_valid(vo[g]), .out_data(yo[g])
    );
  end

  int cf [6] = '{3, -5, 0, 5, -3, 3};
  int hist [6];
  int last [NCFG];
  int exp_cyc [$];
  int exp_acc [$];
  int cyc = 0;
  int n_tests = 0;
  int n_fail = 0;
  int seed = 7;
  string tag = "R9";

  function automatic int model(int acc, int g);
    int q, r, mode;
    bit sat;
    mode = (g < 5) ? g : 0;
    sat  = (g < 5);
    q = acc >>> 2;
    r = acc - q * 4;
    case (mode)
      1: if (r != 0) q++;
      2: if (r >= 2) q++;
      3: if (acc < 0 && r != 0) q++;
      4: if (r > 2 || (r == 2 && (q % 2 != 0))) q++;
      default: ;
    endcase
    if (sat) begin
      if (q > 511) q = 511;
      if (q < -512) q = -512;
    end else begin
      q = q & 1023;
      if (q >= 512) q = q - 1024;
    end
    return q;
  endfunction

  task automatic check_all();
    bit due;
    int e;
    due = (exp_cyc.size() > 0) && (exp_cyc[0] == cyc);
    for (int g = 0; g < NCFG; g++) begin
      n_tests++;
      if (vo[g] !== due) begin
        n_fail++;
        $display("FAIL R1 %s cfg%0d cycle %0d out_valid act=%0b exp=%0b", tag, g, cyc, vo[g], due);
      end else if (due) begin
        e = model(exp_acc[0], g);
        if (int'(yo[g]) != e) begin
          n_fail++;
          $display("FAIL R3 R7 R8 %s cfg%0d cycle %0d data act=%0d exp=%0d", tag, g, cyc, yo[g], e);
        end
        last[g] = e;
      end else if (int'(yo[g]) != last[g]) begin
        n_fail++;
        $display("FAIL R6 %s cfg%0d idle data act=%0d exp=%0d", tag, g, yo[g], last[g]);
      end
    end
    if (due) begin
      void'(exp_cyc.pop_front());
      void'(exp_acc.pop_front());
    end
  endtask

  task automatic step(bit v, int x);
    int acc;
    @(negedge clk);
    cyc++;
    check_all();
    in_valid = v;
    in_data  = 8'(x);
    if (v) begin
      for (int k = 5; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = x;
      acc = 0;
      for (int k = 0; k < 6; k++) acc += cf[k] * hist[k];
      exp_cyc.push_back(cyc + 6);
      exp_acc.push_back(acc);
    end
  endtask

  // R9: reset with a valid sample pending must leave everything cleared
  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 8'sd77;
    repeat (3) @(negedge clk);
    for (int g = 0; g < NCFG; g++) begin
      n_tests++;
      if (vo[g] !== 1'b0 || yo[g] !== '0) begin
        n_fail++;
        $display("FAIL R9 cfg%0d reset state act=%0b/%0d exp=0/0", g, vo[g], yo[g]);
      end
      last[g] = 0;
    end
    for (int k = 0; k < 6; k++) hist[k] = 0;
    exp_cyc.delete();
    exp_acc.delete();
    in_valid = 1'b0;
    rst = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 8; i++) step(1'b0, 0);
  endtask

  initial begin
    do_reset();
    // R10: valid from the first cycle; no output may appear before six edges
    tag = "R10 R1";
    step(1'b1, 100);
    for (int i = 0; i < 7; i++) step(1'b1, 0);
    drain();
    // R4 R5: impulse response exposes each tap, shared and signed
    tag = "R4 R5";
    step(1'b1, 64);
    for (int i = 0; i < 7; i++) step(1'b1, 0);
    step(1'b1, -128);
    for (int i = 0; i < 7; i++) step(1'b1, 0);
    drain();
    // R6: gaps of varying length between valid samples
    tag = "R6";
    for (int i = 0; i < 40; i++) begin
      step(1'b1, (i * 37) % 256 - 128);
      for (int j = 0; j < (i % 4); j++) step(1'b0, 55);
    end
    drain();
    // R2 R3 R7: every input code back to back
    tag = "R2 R3 R7";
    for (int x = -128; x < 128; x++) step(1'b1, x);
    drain();
    // R8: patterns aligned to tap signs push past both output limits
    tag = "R8";
    for (int rep = 0; rep < 3; rep++) begin
      step(1'b1, 127); step(1'b1, -128); step(1'b1, 127);
      step(1'b1, 0);   step(1'b1, -128); step(1'b1, 127);
      step(1'b1, -128); step(1'b1, 127); step(1'b1, -128);
      step(1'b1, 0);   step(1'b1, 127);  step(1'b1, -128);
    end
    drain();
    // R2 R6 R7: pseudo-random data with random gaps
    tag = "R2 R6 R7";
    for (int i = 0; i < 300; i++) begin
      seed = seed * 1103515245 + 12345;
      step(((seed >>> 10) & 3) != 0, ((seed >>> 16) & 255) - 128);
    end
    drain();
    // R9: mid-stream reset, then restart from a clean history
    do_reset();
    tag = "R9 R10";
    for (int i = 0; i < 20; i++) step(1'b1, 120 - i * 11);
    drain();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule